// File: doc/BRIEF.md
# Rotating-Token Four-Port Crossbar Scheduler

This block connects four packet inputs to four packet outputs through a crossbar. The port-to-port configuration is fixed once per round and stays unchanged while the packet bodies move. Each input offers a header that names a destination output or asks for nothing. A priority token sits on one input and moves on by one position every round, so over any four rounds each input holds top priority exactly once.

A round is a fixed series of phases. First the block asks the sources for headers (hdr_req_o) and captures them. It then drops the previous round's configuration and computes the new one from the captured headers and the token. Next it streams a fixed number of body words through the chosen paths. It then signals completion to every granted input and advances the token.

A source whose input gets no completion pulse keeps offering the same header, so a denied packet asks again in the next round. The configuration depends only on the four captured headers and the token position.

Top module: `rtok_xbar`

## Requirements
- R1: A round lasts 6 + BODY_LEN cycles. The phases run in this order: request (1 cycle, hdr_req_o high), capture (1), clear (1), choose (1), body (BODY_LEN), confirm (1) and token update (1). hdr_req_o is high only in the request cycle.
- R2: A header code from 0 to 3 names that output. Codes 4 to 7 mean no request. Headers are sampled only at the end of the capture cycle, and changes to hdr_i at any other time have no effect on that round.
- R3: Grants are resolved in ring order. The order starts at the token holder and goes up in index, modulo 4. An input gets its output only if no input earlier in that order has already claimed the same output.
- R4: No output is fed by more than one input in a round. During the body phase, the number of valid outputs equals the number of inputs being read.
- R5: grant_o bit i is high from the end of the choose cycle until the end of the next round's clear cycle, and only for input i when its request won. Inputs without a request and inputs that lost are never granted.
- R6: In each body cycle, in_pop_o is high for every granted input. Every output fed by a granted input carries that input's current in_data_i word.
- R7: out_valid_o is low outside the body phase and on outputs that no input won. An output that is not valid drives zero data.
- R8: done_o pulses for one cycle, in the confirm phase, on exactly the granted inputs.
- R9: token_o changes only at the end of the token-update cycle, and then becomes (token_o + 1) mod 4.
- R10: While rst_ni is low, token_o is 0, all grants are clear, hdr_req_o is high and all outputs are invalid. After release, the first cycle is the request phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_i | input | 4x3 | Header per input: 0-3 names an output, 4-7 means no request |
| in_data_i | input | 4xDW | Body word offered by each input |
| hdr_req_o | output | 1 | Request-headers phase indicator |
| grant_o | output | 4 | Inputs granted in the current configuration |
| in_pop_o | output | 4 | Body word taken from each input this cycle |
| out_data_o | output | 4xDW | Body word on each output |
| out_valid_o | output | 4 | Output carries a body word this cycle |
| done_o | output | 4 | Completion pulse per granted input |
| token_o | output | 2 | Index of the current token holder |

## Verification
A token that is off by one position, or that moves in the wrong phase, shows up on token_o within one cycle of the update phase. From the next choose cycle it also shows up on grant_o whenever two inputs ask for the same output. A sequencer that is out of step moves hdr_req_o, in_pop_o or done_o away from their slots within a single round. A wrong source selection shows up as a wrong data word on the very first body beat. Stale captured headers show up as wrong grants in the round that reads them, because the stimulus changes hdr_i on every cycle outside the capture cycle.

// File: rtl/rtok_pkg.sv
package rtok_pkg;
  typedef enum logic [2:0] {
    PH_REQ,
    PH_RECV,
    PH_XCHG,
    PH_CHOOSE,
    PH_BODY,
    PH_CONF,
    PH_TOKEN
  } phase_e;
endpackage

// File: rtl/rtok_seq.sv
module rtok_seq
  import rtok_pkg::*;
#(
  parameter int NP       = 4,
  parameter int BODY_LEN = 4,
  localparam int PW = $clog2(NP),
  localparam int BW = (BODY_LEN > 1) ? $clog2(BODY_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output phase_e        phase_o,
  output logic [PW-1:0] token_o
);
  phase_e        phase_q;
  logic [BW-1:0] beat_q;
  logic [PW-1:0] token_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_REQ;
      beat_q  <= '0;
      token_q <= '0;
    end else begin
      case (phase_q)
        PH_REQ:    phase_q <= PH_RECV;
        PH_RECV:   phase_q <= PH_XCHG;
        PH_XCHG:   phase_q <= PH_CHOOSE;
        PH_CHOOSE: begin
          phase_q <= PH_BODY;
          beat_q  <= '0;
        end
        PH_BODY: begin
          if (beat_q == BW'(BODY_LEN - 1)) phase_q <= PH_CONF;
          else beat_q <= beat_q + 1'b1;
        end
        PH_CONF:   phase_q <= PH_TOKEN;
        PH_TOKEN: begin
          token_q <= token_q + 1'b1;
          phase_q <= PH_REQ;
        end
        default:   phase_q <= PH_REQ;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign token_o = token_q;
endmodule

// File: rtl/rtok_arb.sv
module rtok_arb #(
  parameter int NP = 4,
  localparam int PW = $clog2(NP),
  localparam int HW = PW + 1
) (
  input  logic [NP-1:0][HW-1:0] hdr_i,
  input  logic [PW-1:0]         token_i,
  output logic [NP-1:0]         gnt_o,
  output logic [NP-1:0][PW-1:0] src_o,
  output logic [NP-1:0]         used_o
);
  // walk the ring from the token holder; first claimant of an output wins
  always_comb begin
    gnt_o  = '0;
    src_o  = '0;
    used_o = '0;
    for (int k = 0; k < NP; k++) begin
      int idx;
      int dst;
      idx = (int'(token_i) + k) % NP;
      dst = int'(hdr_i[idx]);
      if (dst < NP) begin
        if (!used_o[dst]) begin
          used_o[dst] = 1'b1;
          gnt_o[idx]  = 1'b1;
          src_o[dst]  = PW'(idx);
        end
      end
    end
  end
endmodule

// File: rtl/rtok_route.sv
module rtok_route #(
  parameter int NP = 4,
  parameter int DW = 8,
  localparam int PW = $clog2(NP)
) (
  input  logic                  en_i,
  input  logic [NP-1:0][DW-1:0] in_data_i,
  input  logic [NP-1:0][PW-1:0] src_i,
  input  logic [NP-1:0]         used_i,
  output logic [NP-1:0][DW-1:0] out_data_o,
  output logic [NP-1:0]         out_valid_o
);
  for (genvar o = 0; o < NP; o++) begin : g_out
    assign out_valid_o[o] = en_i & used_i[o];
    assign out_data_o[o]  = out_valid_o[o] ? in_data_i[src_i[o]] : '0;
  end
endmodule

// File: rtl/rtok_xbar.sv
module rtok_xbar
  import rtok_pkg::*;
#(
  parameter int NP       = 4,
  parameter int DW       = 8,
  parameter int BODY_LEN = 4,
  localparam int PW = $clog2(NP),
  localparam int HW = PW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NP-1:0][HW-1:0] hdr_i,
  input  logic [NP-1:0][DW-1:0] in_data_i,
  output logic                  hdr_req_o,
  output logic [NP-1:0]         grant_o,
  output logic [NP-1:0]         in_pop_o,
  output logic [NP-1:0][DW-1:0] out_data_o,
  output logic [NP-1:0]         out_valid_o,
  output logic [NP-1:0]         done_o,
  output logic [PW-1:0]         token_o
);
  phase_e                phase;
  logic [PW-1:0]         token;
  logic [NP-1:0][HW-1:0] hdr_q;
  logic [NP-1:0]         grant_q;
  logic [NP-1:0][PW-1:0] src_q;
  logic [NP-1:0]         used_q;
  logic [NP-1:0]         arb_gnt;
  logic [NP-1:0][PW-1:0] arb_src;
  logic [NP-1:0]         arb_used;
  logic                  in_body;

  rtok_seq #(.NP(NP), .BODY_LEN(BODY_LEN)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .token_o (token)
  );

  rtok_arb #(.NP(NP)) u_arb (
    .hdr_i   (hdr_q),
    .token_i (token),
    .gnt_o   (arb_gnt),
    .src_o   (arb_src),
    .used_o  (arb_used)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q   <= '1;
      grant_q <= '0;
      src_q   <= '0;
      used_q  <= '0;
    end else begin
      case (phase)
        PH_RECV: hdr_q <= hdr_i;
        PH_XCHG: begin
          grant_q <= '0;
          used_q  <= '0;
        end
        PH_CHOOSE: begin
          grant_q <= arb_gnt;
          src_q   <= arb_src;
          used_q  <= arb_used;
        end
        default: ;
      endcase
    end
  end

  assign in_body = (phase == PH_BODY);

  rtok_route #(.NP(NP), .DW(DW)) u_route (
    .en_i        (in_body),
    .in_data_i   (in_data_i),
    .src_i       (src_q),
    .used_i      (used_q),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o)
  );

  assign hdr_req_o = (phase == PH_REQ);
  assign grant_o   = grant_q;
  assign in_pop_o  = in_body ? grant_q : '0;
  assign done_o    = (phase == PH_CONF) ? grant_q : '0;
  assign token_o   = token;
endmodule

// File: rtl/rtok_xbar_chk.sv
module rtok_xbar_chk #(
  parameter int NP = 4,
  localparam int PW = $clog2(NP)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hdr_req_o,
  input logic [NP-1:0] grant_o,
  input logic [NP-1:0] in_pop_o,
  input logic [NP-1:0] out_valid_o,
  input logic [NP-1:0] done_o,
  input logic [PW-1:0] token_o
);
  AST_ONE_SRC_PER_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(out_valid_o) == $countones(in_pop_o)); // R4
  AST_POP_ONLY_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pop_o & ~grant_o) == '0); // R6
  AST_REQ_PHASE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_req_o |-> (out_valid_o == '0 && done_o == '0 && in_pop_o == '0)); // R1
  AST_DONE_AFTER_BODY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0 && $past(rst_ni)) |-> ($past(in_pop_o) == done_o)); // R8
  AST_TOKEN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(token_o) && $past(rst_ni)) |-> (token_o == $past(token_o) + 1'b1 && hdr_req_o)); // R9
endmodule

bind rtok_xbar rtok_xbar_chk #(.NP(NP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hdr_req_o   (hdr_req_o),
  .grant_o     (grant_o),
  .in_pop_o    (in_pop_o),
  .out_valid_o (out_valid_o),
  .done_o      (done_o),
  .token_o     (token_o)
);

// File: tb/rtok_xbar_bench.sv
module rtok_xbar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DW = 8;
  localparam int L  = 4;
  localparam int RL = 6 + L;
  localparam int NCYC = 600;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NP-1:0][2:0]   hdr = '1;
  logic [NP-1:0][DW-1:0] din = '0;
  logic                 hdr_req;
  logic [NP-1:0]        grant, pop, vld, done;
  logic [NP-1:0][DW-1:0] dout;
  logic [1:0]           token;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  int m_c = 0, m_tok = 0;
  int m_hdr [NP];
  bit m_gnt [NP];
  int m_src [NP];
  bit m_used[NP];
  int pend  [NP];

  rtok_xbar #(.NP(NP), .DW(DW), .BODY_LEN(L)) u_rtok_xbar (
    .clk_i(clk), .rst_ni(rst_n), .hdr_i(hdr), .in_data_i(din),
    .hdr_req_o(hdr_req), .grant_o(grant), .in_pop_o(pop),
    .out_data_o(dout), .out_valid_o(vld), .done_o(done), .token_o(token)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_c = 0; m_tok = 0;
    for (int i = 0; i < NP; i++) begin
      m_gnt[i] = 0; m_used[i] = 0; m_src[i] = 0; m_hdr[i] = 7;
    end
  endfunction

  // model advances on each clock edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (m_c == 1) for (int i = 0; i < NP; i++) m_hdr[i] = int'(hdr[i]);
      if (m_c == 2) for (int i = 0; i < NP; i++) begin m_gnt[i] = 0; m_used[i] = 0; end
      if (m_c == 3) begin
        bit taken[NP];
        for (int o = 0; o < NP; o++) taken[o] = 0;
        for (int k = 0; k < NP; k++) begin
          int who;
          who = (m_tok + k) % NP;
          if (m_hdr[who] < NP && !taken[m_hdr[who]]) begin
            taken[m_hdr[who]] = 1;
            m_gnt[who] = 1;
            m_src[m_hdr[who]] = who;
          end
        end
        for (int o = 0; o < NP; o++) m_used[o] = taken[o];
      end
      if (m_c == RL - 1) m_tok = (m_tok + 1) % NP;
      m_c = (m_c + 1) % RL;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    bit body, conf;
    if (!rst_n) begin
      model_reset();
      chk("R10 token", int'(token), 0);
      chk("R10 grant", int'(grant), 0);
      chk("R10 hdr_req", int'(hdr_req), 1);
      chk("R10 valid", int'(vld), 0);
    end
    body = (m_c >= 4 && m_c < 4 + L);
    conf = (m_c == 4 + L);
    chk("R9 token", int'(token), m_tok);
    chk("R1 hdr_req", int'(hdr_req), (m_c == 0) ? 1 : 0);
    for (int i = 0; i < NP; i++) begin
      chk("R2 R3 R5 grant", int'(grant[i]), int'(m_gnt[i]));
      chk("R6 pop", int'(pop[i]), int'(body && m_gnt[i]));
      chk("R8 done", int'(done[i]), int'(conf && m_gnt[i]));
      if (conf && done[i]) pend[i] = $urandom % 8;
    end
    for (int o = 0; o < NP; o++) begin
      bit ve;
      ve = body && m_used[o];
      chk("R7 valid", int'(vld[o]), int'(ve));
      chk("R6 R7 data", int'(dout[o]), ve ? int'(din[m_src[o]]) : 0);
    end
    chk("R4 single source", $countones(vld), $countones(pop));
  end

  function automatic int pattern(int r, int i);
    case (r % 6)
      0: return 2;                 // everyone wants output 2
      1: return 4 + (i % 4);       // no requests, all codes 4..7
      2: return i;                 // distinct outputs
      3: return (i < 2) ? 1 : 5;   // pair contends, others idle
      4: return pend[i];           // losers repeat their header
      default: return int'($urandom % 8);
    endcase
  endfunction

  initial begin
    int round;
    round = 0;
    for (int i = 0; i < NP; i++) pend[i] = i;
    model_reset();
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      #1;
      for (int i = 0; i < NP; i++) din[i] = DW'($urandom);
      if (cyc == 313) rst_n = 1'b0;          // mid-run reset, R10
      if (cyc == 316) rst_n = 1'b1;
      if (m_c == 1 && rst_n) begin
        for (int i = 0; i < NP; i++) hdr[i] = 3'(pattern(round, i));
        round++;
      end else begin
        // scrambled outside capture: must be ignored (R2)
        for (int i = 0; i < NP; i++) hdr[i] = 3'($urandom);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * (NCYC + 200));
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule